// File: doc/BRIEF.md
# Warp Load Coalescer

This block turns one warp's load request into the shortest list of aligned memory transactions that can serve it. A request carries 32 lane byte addresses and an active-lane mask. Each active lane wants one 4-byte word. The block finds every distinct 128-byte aligned block that the active lanes touch. It then issues one transaction per block, lowest block first, on a valid/ready output stream.

When the last transaction has been handed off, a one-cycle `done` pulse reports three results: the number of transactions, the useful bytes (distinct words times 4) and the hauled bytes (transactions times 128). The request side is also valid/ready. `req_ready` is high only while the block is idle, so a new request cannot enter while one is still being served. On the transaction side, a low `txn_ready` stalls the block. While stalled, `txn_valid` stays high and `txn_addr` holds its value until the handshake completes.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1, `txn_valid` is 0, `done` is 0, and all three `done_*` counts are 0.
- R2: A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low while any transaction of that request is pending. It returns high in the same cycle that `done` pulses.
- R3: The block issues exactly one transaction for each distinct 128-byte block touched by an active lane. Each `txn_addr` has bits [6:0] equal to zero.
- R4: Within one request, transaction addresses are strictly ascending.
- R5: If `txn_valid` is high and `txn_ready` is low, then on the next cycle `txn_valid` is still high and `txn_addr` is unchanged.
- R6: Lanes whose mask bit is 0 do not change the transactions or any count, whatever their addresses are.
- R7: A request with an all-zero mask issues no transaction. `done` pulses in the cycle after acceptance, and all counts are 0.
- R8: `done` is high for the cycle right after the final transaction handshake. `done_txn_count` then equals the number of transactions handed off.
- R9: `done_useful_bytes` is 4 times the number of distinct word addresses among active lanes. `done_hauled_bytes` is 128 times `done_txn_count`.
- R10: If every active lane gives the same address, exactly one transaction is issued and the useful-byte count is 4. A single active lane also costs one transaction.
- R11: These patterns give the following transaction counts:
  - consecutive words from an aligned base: 1
  - a 2-word stride: 2
  - a 32-word stride: 32
  - a 24-byte stride: 6
  - consecutive words from byte offset 64: 2

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mask | input | LANES | Active-lane mask, bit i for lane i |
| req_addr | input | LANES*ADDR_W | Lane byte addresses; lane i at bits [i*ADDR_W +: ADDR_W] |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_addr | output | ADDR_W | 128-byte aligned block address |
| done | output | 1 | One-cycle pulse: request finished |
| done_txn_count | output | CNT_W | Transactions issued for the finished request |
| done_useful_bytes | output | UB_W | Distinct useful bytes delivered |
| done_hauled_bytes | output | HB_W | Bytes fetched in whole blocks |

## Verification
The assertions assume that lane addresses are word aligned (bits [1:0] zero), because each lane asks for one whole 4-byte word. They also assume that `req_valid` is only raised while no request is in flight, as the handshake requires. The stimulus builds every address as a base plus a multiple of 4, and it waits for `done` before it presents the next request. Random masks, strides and clustered offsets exercise overlapping blocks and repeated words. The downstream ready signal is dropped at random to create back-pressure.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coal_state_e;
endpackage

// File: rtl/coal_min_finder.sv
// Picks the lowest block number among lanes still pending, and flags
// every pending lane that sits in that block.
module coal_min_finder #(
  parameter int LANES = 32,
  parameter int BW    = 25
) (
  input  logic [LANES*BW-1:0] blk_flat,
  input  logic [LANES-1:0]    pend,
  output logic [BW-1:0]       min_blk,
  output logic [LANES-1:0]    hit
);
  always_comb begin
    logic found;
    found   = 1'b0;
    min_blk = '1;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && (!found || blk_flat[i*BW +: BW] < min_blk)) begin
        min_blk = blk_flat[i*BW +: BW];
        found   = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_hit
    assign hit[g] = pend[g] && (blk_flat[g*BW +: BW] == min_blk);
  end
endmodule

// File: rtl/coal_distinct.sv
// Counts distinct word addresses among active lanes: a lane counts only
// if no lower-numbered active lane holds the same word.
module coal_distinct #(
  parameter int LANES = 32,
  parameter int WW    = 30,
  parameter int CNT_W = 6
) (
  input  logic [LANES*WW-1:0] word_flat,
  input  logic [LANES-1:0]    act,
  output logic [CNT_W-1:0]    count
);
  logic [LANES-1:0] first;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic dup;
    always_comb begin
      dup = 1'b0;
      for (int j = 0; j < g; j++) begin
        if (act[j] && word_flat[j*WW +: WW] == word_flat[g*WW +: WW]) dup = 1'b1;
      end
    end
    assign first[g] = act[g] && !dup;
  end

  assign count = CNT_W'($countones(first));
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES       = 32,
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_BYTES = 128,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int UB_W  = $clog2(LANES * WORD_BYTES + 1),
  localparam int HB_W  = $clog2(LANES * BLOCK_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_mask,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_addr,
  output logic                    done,
  output logic [CNT_W-1:0]        done_txn_count,
  output logic [UB_W-1:0]         done_useful_bytes,
  output logic [HB_W-1:0]         done_hauled_bytes
);
  import coal_pkg::*;

  localparam int BLK_SH  = $clog2(BLOCK_BYTES);
  localparam int WORD_SH = $clog2(WORD_BYTES);
  localparam int BW      = ADDR_W - BLK_SH;
  localparam int WW      = ADDR_W - WORD_SH;

  coal_state_e             state_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        mask_q;
  logic [LANES-1:0]        pend_q;
  logic [CNT_W-1:0]        txn_cnt_q;
  logic                    done_q;
  logic [CNT_W-1:0]        done_cnt_q;
  logic [UB_W-1:0]         done_ub_q;
  logic [HB_W-1:0]         done_hb_q;

  logic [LANES*BW-1:0]     blk_flat;
  logic [LANES*WW-1:0]     word_flat;
  logic [BW-1:0]           min_blk;
  logic [LANES-1:0]        hit;
  logic [CNT_W-1:0]        uniq_words;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign blk_flat[g*BW +: BW]  = addr_q[g*ADDR_W + BLK_SH +: BW];
    assign word_flat[g*WW +: WW] = addr_q[g*ADDR_W + WORD_SH +: WW];
  end

  coal_min_finder #(.LANES(LANES), .BW(BW)) u_min (
    .blk_flat (blk_flat),
    .pend     (pend_q),
    .min_blk  (min_blk),
    .hit      (hit)
  );

  coal_distinct #(.LANES(LANES), .WW(WW), .CNT_W(CNT_W)) u_dist (
    .word_flat (word_flat),
    .act       (mask_q),
    .count     (uniq_words)
  );

  logic accept, hs, last_hs;
  logic [CNT_W-1:0] cnt_next;

  assign req_ready = (state_q == ST_IDLE);
  assign txn_valid = (state_q == ST_BUSY);
  assign txn_addr  = {min_blk, {BLK_SH{1'b0}}};
  assign accept    = req_valid && req_ready;
  assign hs        = txn_valid && txn_ready;
  assign last_hs   = hs && ((pend_q & ~hit) == '0);
  assign cnt_next  = txn_cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      mask_q     <= '0;
      pend_q     <= '0;
      txn_cnt_q  <= '0;
      done_q     <= 1'b0;
      done_cnt_q <= '0;
      done_ub_q  <= '0;
      done_hb_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        addr_q    <= req_addr;
        mask_q    <= req_mask;
        pend_q    <= req_mask;
        txn_cnt_q <= '0;
        if (req_mask == '0) begin
          done_q     <= 1'b1;
          done_cnt_q <= '0;
          done_ub_q  <= '0;
          done_hb_q  <= '0;
        end else begin
          state_q <= ST_BUSY;
        end
      end else if (hs) begin
        pend_q    <= pend_q & ~hit;
        txn_cnt_q <= cnt_next;
        if (last_hs) begin
          state_q    <= ST_IDLE;
          done_q     <= 1'b1;
          done_cnt_q <= cnt_next;
          done_ub_q  <= UB_W'(uniq_words) << WORD_SH;
          done_hb_q  <= HB_W'(cnt_next) << BLK_SH;
        end
      end
    end
  end

  assign done              = done_q;
  assign done_txn_count    = done_cnt_q;
  assign done_useful_bytes = done_ub_q;
  assign done_hauled_bytes = done_hb_q;
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int LANES       = 32,
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 128,
  parameter int CNT_W       = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LANES-1:0]  req_mask,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [ADDR_W-1:0] txn_addr,
  input logic              done,
  input logic [CNT_W-1:0]  done_txn_count
);
  localparam int BLK_SH = $clog2(BLOCK_BYTES);

  logic              have_last;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_addr <= '0;
    end else if (txn_valid && txn_ready) begin
      have_last <= 1'b1;
      last_addr <= txn_addr;
    end else if (done) begin
      have_last <= 1'b0;
    end
  end

  assert_txn_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_addr[BLK_SH-1:0] == '0);

  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && have_last && !done) |-> txn_addr > last_addr);

  assert_hold_under_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr)));

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

  assert_empty_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mask == '0) |=> (done && done_txn_count == '0 && !txn_valid));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !txn_valid));
endmodule

bind warp_coalescer coal_checker #(
  .LANES(LANES), .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mask(req_mask), .txn_valid(txn_valid), .txn_ready(txn_ready),
  .txn_addr(txn_addr), .done(done), .done_txn_count(done_txn_count)
);

// File: tb/tb_warp_coalescer.sv
module tb_warp_coalescer;
  localparam int L = 32;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [L-1:0] req_mask = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic txn_valid;
  logic txn_ready = 1'b0;
  logic [AW-1:0] txn_addr;
  logic done;
  logic [5:0] done_txn_count;
  logic [7:0] done_useful_bytes;
  logic [12:0] done_hauled_bytes;

  always #4 clk = ~clk;

  warp_coalescer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_addr(req_addr), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_addr(txn_addr), .done(done),
    .done_txn_count(done_txn_count), .done_useful_bytes(done_useful_bytes),
    .done_hauled_bytes(done_hauled_bytes)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [AW-1:0] a [L];
  logic [L-1:0]  m;
  logic [AW-1:0] exp_blk [L];
  int            exp_n;
  int            exp_words;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Sorted list of distinct blocks and count of distinct words, active lanes only.
  task automatic model();
    logic [AW-1:0] words [L];
    exp_n = 0;
    exp_words = 0;
    for (int i = 0; i < L; i++) begin
      if (m[i]) begin
        logic [AW-1:0] b;
        bit seen;
        b = a[i] & ~32'd127;
        seen = 1'b0;
        for (int k = 0; k < exp_n; k++) if (exp_blk[k] == b) seen = 1'b1;
        if (!seen) begin
          int p;
          p = exp_n;
          while (p > 0 && exp_blk[p-1] > b) begin
            exp_blk[p] = exp_blk[p-1];
            p--;
          end
          exp_blk[p] = b;
          exp_n++;
        end
        seen = 1'b0;
        for (int k = 0; k < exp_words; k++) if (words[k] == a[i]) seen = 1'b1;
        if (!seen) begin
          words[exp_words] = a[i];
          exp_words++;
        end
      end
    end
  endtask

  task automatic run(input string tag, input int want_n);
    int got;
    int cyc;
    bit stalled;
    logic [AW-1:0] stall_addr;
    model();
    if (want_n >= 0) check(exp_n == want_n, tag, "model count", exp_n, want_n);
    @(negedge clk);
    check(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_mask  = m;
    for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = a[i];
    @(posedge clk);
    got = 0;
    cyc = 0;
    stalled = 1'b0;
    stall_addr = '0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
      if (stalled) begin
        check(txn_valid && txn_addr == stall_addr, "R5", "addr held",
              txn_addr, stall_addr);
        stalled = 1'b0;
      end
      if (done) break;
      if (cyc > 400) begin
        check(1'b0, "R8", "done timeout", cyc, 400);
        break;
      end
      if (txn_valid) begin
        check(req_ready == 1'b0, "R2", "ready low while busy", req_ready, 0);
      end
      txn_ready = ($urandom % 4) != 0;
      if (txn_valid) begin
        if (txn_ready) begin
          if (got < exp_n)
            check(txn_addr == exp_blk[got], "R3", {tag, " txn addr"},
                  txn_addr, exp_blk[got]);
          else
            check(1'b0, "R3", {tag, " extra txn"}, got + 1, exp_n);
          got++;
        end else begin
          stalled = 1'b1;
          stall_addr = txn_addr;
        end
      end
    end
    txn_ready = 1'b0;
    check(got == exp_n, "R3", {tag, " txn total"}, got, exp_n);
    check(req_ready == 1'b1, "R2", "ready with done", req_ready, 1);
    check(done_txn_count == exp_n, "R8", {tag, " done count"}, done_txn_count, exp_n);
    check(done_useful_bytes == 4 * exp_words, "R9", {tag, " useful"},
          done_useful_bytes, 4 * exp_words);
    check(done_hauled_bytes == 128 * exp_n, "R9", {tag, " hauled"},
          done_hauled_bytes, 128 * exp_n);
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", done, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [AW-1:0] base;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1 && txn_valid == 0 && done == 0, "R1", "idle flags",
          {req_ready, txn_valid, done}, 3'b100);
    check(done_txn_count == 0 && done_useful_bytes == 0 && done_hauled_bytes == 0,
          "R1", "counts zero", done_txn_count, 0);

    base = 32'h0000_4000;
    m = '1;
    for (int i = 0; i < L; i++) a[i] = base + 4 * i;
    run("R11 consecutive", 1);
    for (int i = 0; i < L; i++) a[i] = base + 8 * i;
    run("R11 stride2", 2);
    for (int i = 0; i < L; i++) a[i] = base + 128 * i;
    run("R11 stride32", 32);
    for (int i = 0; i < L; i++) a[i] = base + 24 * i;
    run("R11 stride24", 6);
    for (int i = 0; i < L; i++) a[i] = base + 64 + 4 * i;
    run("R11 offset64", 2);
    for (int i = 0; i < L; i++) a[i] = 32'h0000_9a3c;
    run("R10 broadcast", 1);
    check(exp_words == 1, "R10", "broadcast words", exp_words, 1);
    m = 32'h0000_0001;
    for (int i = 0; i < L; i++) a[i] = base + 4096 * i;
    run("R10 single lane", 1);
    // R6: odd lanes point far away but are masked off
    m = 32'h5555_5555;
    for (int i = 0; i < L; i++) a[i] = (i % 2 == 0) ? base + 4 * i : 32'hF000_0000 + 512 * i;
    run("R6 masked", 1);
    // R7 empty mask
    m = '0;
    run("R7 empty", 0);
    // descending addresses must still come out ascending (R4)
    m = '1;
    for (int i = 0; i < L; i++) a[i] = base + 128 * (L - 1 - i);
    run("R4 reversed", 32);

    for (int n = 0; n < 80; n++) begin
      int stride;
      m = (($urandom % 5) == 0) ? 32'($urandom & $urandom) : 32'($urandom);
      base = $urandom & 32'hFFFF_FFFC;
      base[31:28] = 4'h1;
      stride = 4 * ($urandom % 40);
      for (int i = 0; i < L; i++) begin
        if (n % 2 == 0) a[i] = base + stride * i;
        else a[i] = base + 4 * ($urandom % 200);
      end
      run("R3 random", -1);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule